// File: doc/BRIEF.md
# Radix-2 Fixed-Point Row Transform Engine

This block computes a 32-point complex discrete Fourier transform, forward or inverse, on one row of samples held entirely in registers. All samples are signed 27-bit fixed point with 7 fractional bits. The real parts and the imaginary parts each arrive as one flat packed vector. A single-cycle start pulse captures both vectors and the direction input, and the results come back in vectors of the same shape. A one-cycle done pulse marks the point where the results are valid.

Each run has two phases. The first phase walks an index across the row and swaps each element with the element at its bit-reversed position, which leaves the row as a set of one-point transforms. The second phase merges pairs of transforms into transforms twice as long, one butterfly at a time, until a single 32-point transform remains. The twiddle factors are read from a small sine table, which supplies the cosine at a quarter-period offset. The forward direction halves its values at every stage, so the output is the spectrum divided by 32 and cannot overflow. The inverse direction applies no scaling and rotates the other way.

Top module: `fft_row_engine`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and both output vectors are all zeros.
- R2: With `inverse`=0, the result equals a decimation-in-time radix-2 transform using the twiddle W = c - j*s. At every stage the two twiddle-product sums and the element at the upper index i are each arithmetically shifted right by one bit. For example, a real impulse of 4096 at element 0 gives 128 real and 0 imaginary in every bin.
- R3: With `inverse`=1, the same structure uses W = c + j*s, and nothing is shifted. For example, a real impulse of 128 at element 0 gives 128 real in every element.
- R4: Twiddles come from a table of 32 entries with s[k] = round(sin(2*pi*k/32)*128), so that +1.0 is 128. The cosine for index k is s[(k+8) mod 32]. The stage with half-length L uses index k = g*(16/L) for group g. An inverse transform of a single real bin at frequency 1 therefore gives a positive imaginary part at element 8.
- R5: `done` is high for exactly one cycle. It rises 254 clock edges after the edge that samples `start`, where 254 = N + 2(N-1) + N*log2(N).
- R6: A `start` pulse that arrives while a transform is running is ignored. This covers its data and its direction, and neither the timing nor the results of the running transform change.
- R7: After `done`, the output vectors hold their values until the next accepted `start`.
- R8: Each product is the full signed 27x27 product, shifted arithmetically right by 7 and cut to 27 bits. Sums and differences wrap at 27 bits.
- R9: Element k of a row occupies bits [27k+26 : 27k] of its packed vector, for inputs and outputs alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to capture a row and begin a transform |
| inverse | input | 1 | Direction: 0 forward (scaled), 1 inverse (unscaled) |
| re_in | input | 864 | Real parts of the 32 input elements, packed |
| im_in | input | 864 | Imaginary parts of the 32 input elements, packed |
| re_out | output | 864 | Real parts of the 32 result elements, packed |
| im_out | output | 864 | Imaginary parts of the 32 result elements, packed |
| done | output | 1 | One-cycle pulse when the results are valid |

## Verification
The bench drives impulses in both directions, a single inverse bin, a ramp placed at distinct element positions, and random rows. It compares every element bit-for-bit against a behavioural reference and checks `done` against its expected cycle on every clock. Each stimulus targets a specific defect. A sine with the wrong sign or a cosine read at the wrong offset makes the single-bin case rotate the wrong way. A missing or misplaced halving breaks the flat 128 level of the forward impulse. A broken bit-reversal or a broken packing order scrambles the ramp. A mid-run `start` with different data and the opposite direction must leave the result and the timing unchanged, which exposes an engine that restarts or relatches its mode. The bench also reads the outputs three cycles after `done`, so any drift after completion shows up as a mismatch.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REORD,
    ST_TWC,
    ST_TWS,
    ST_BFM,
    ST_BFU,
    ST_FIN
  } fft_state_e;

  // reverse the low 'bits' bits of v
  function automatic int unsigned bit_reverse(input int unsigned v, input int unsigned bits);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < bits; b++) begin
      r = (r << 1) | ((v >> b) & 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fft_rst_sync.sv
module fft_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/fft_fxmul.sv
module fft_fxmul #(
  parameter int DW   = 27,
  parameter int FRAC = 7
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;

  assign prod = PW'(a) * PW'(b);
  assign y    = DW'(prod >>> FRAC);
endmodule

// File: rtl/fft_sine_rom.sv
module fft_sine_rom #(
  parameter int NPTS = 32,
  parameter int DW   = 27,
  parameter int FRAC = 7
) (
  input  logic [$clog2(NPTS)-1:0] addr,
  output logic signed [DW-1:0]    data
);
  localparam real TWO_PI = 6.283185307179586;
  localparam real SCALE  = real'(1 << FRAC);

  logic signed [DW-1:0] tbl [NPTS];

  for (genvar k = 0; k < NPTS; k++) begin : g_ent
    localparam real ANG = TWO_PI * real'(k) / real'(NPTS);
    localparam int  VAL = $rtoi($floor($sin(ANG) * SCALE + 0.5));
    assign tbl[k] = DW'(VAL);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/fft_row_engine.sv
module fft_row_engine
  import fft_pkg::*;
#(
  parameter int NPTS = 32,
  parameter int DW   = 27,
  parameter int FRAC = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 inverse,
  input  logic [NPTS*DW-1:0]   re_in,
  input  logic [NPTS*DW-1:0]   im_in,
  output logic [NPTS*DW-1:0]   re_out,
  output logic [NPTS*DW-1:0]   im_out,
  output logic                 done
);
  localparam int LOGN = $clog2(NPTS);
  localparam int SW   = (LOGN > 2) ? $clog2(LOGN) : 1;
  localparam int QTR  = NPTS / 4;
  localparam int NMUL = 4;

  logic rst_q;

  fft_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  // state and loop counters
  fft_state_e      st,  st_n;
  logic [LOGN-1:0] m,   m_n;
  logic [SW-1:0]   stg, stg_n;
  logic [LOGN-1:0] grp, grp_n;
  logic [LOGN-1:0] bi,  bi_n;
  logic            inv_q;

  // row storage
  logic signed [DW-1:0] xr [NPTS];
  logic signed [DW-1:0] xi [NPTS];

  // twiddle and products
  logic signed [DW-1:0] wr_q, wi_q;
  logic signed [DW-1:0] mul_a [NMUL];
  logic signed [DW-1:0] mul_b [NMUL];
  logic signed [DW-1:0] mul_p [NMUL];
  logic signed [DW-1:0] prod_q [NMUL];

  // address arithmetic
  logic [LOGN-1:0] mr;
  logic            do_swap;
  logic [LOGN-1:0] span;
  logic [LOGN-1:0] j_idx;
  logic [LOGN-1:0] tw_idx;
  logic [LOGN-1:0] rom_addr;
  logic signed [DW-1:0] rom_d;
  logic [LOGN:0]   nxt_bi;
  logic [LOGN:0]   grp_inc;

  assign mr       = LOGN'(bit_reverse(32'(m), LOGN));
  assign do_swap  = (m < mr);
  assign span     = LOGN'(1) << stg;
  assign j_idx    = bi + span;
  assign tw_idx   = grp << (SW'(LOGN - 1) - stg);
  assign rom_addr = (st == ST_TWC) ? (tw_idx + LOGN'(QTR)) : tw_idx;
  assign nxt_bi   = (LOGN+1)'(bi) + ((LOGN+1)'(span) << 1);
  assign grp_inc  = (LOGN+1)'(grp) + (LOGN+1)'(1);

  fft_sine_rom #(.NPTS(NPTS), .DW(DW), .FRAC(FRAC)) u_rom (
    .addr (rom_addr),
    .data (rom_d)
  );

  // products: wr*xr_j, wi*xi_j, wr*xi_j, wi*xr_j
  always_comb begin
    mul_a[0] = wr_q;  mul_b[0] = xr[j_idx];
    mul_a[1] = wi_q;  mul_b[1] = xi[j_idx];
    mul_a[2] = wr_q;  mul_b[2] = xi[j_idx];
    mul_a[3] = wi_q;  mul_b[3] = xr[j_idx];
  end

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    fft_fxmul #(.DW(DW), .FRAC(FRAC)) u_mul (
      .a (mul_a[g]),
      .b (mul_b[g]),
      .y (mul_p[g])
    );
  end

  // butterfly combine
  logic signed [DW-1:0] tr_w, ti_w, tr_s, ti_s, qr_s, qi_s;

  always_comb begin
    tr_w = prod_q[0] - prod_q[1];
    ti_w = prod_q[2] + prod_q[3];
    if (inv_q) begin
      tr_s = tr_w;
      ti_s = ti_w;
      qr_s = xr[bi];
      qi_s = xi[bi];
    end else begin
      tr_s = tr_w >>> 1;
      ti_s = ti_w >>> 1;
      qr_s = xr[bi] >>> 1;
      qi_s = xi[bi] >>> 1;
    end
  end

  // next-state process
  always_comb begin
    st_n  = st;
    m_n   = m;
    stg_n = stg;
    grp_n = grp;
    bi_n  = bi;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          st_n = ST_REORD;
          m_n  = '0;
        end
      end
      ST_REORD: begin
        if (m == LOGN'(NPTS - 1)) begin
          st_n  = ST_TWC;
          stg_n = '0;
          grp_n = '0;
        end else begin
          m_n = m + LOGN'(1);
        end
      end
      ST_TWC: st_n = ST_TWS;
      ST_TWS: begin
        st_n = ST_BFM;
        bi_n = grp;
      end
      ST_BFM: st_n = ST_BFU;
      ST_BFU: begin
        if (nxt_bi < (LOGN+1)'(NPTS)) begin
          bi_n = LOGN'(nxt_bi);
          st_n = ST_BFM;
        end else if (grp_inc < (LOGN+1)'(span)) begin
          grp_n = LOGN'(grp_inc);
          st_n  = ST_TWC;
        end else if (stg == SW'(LOGN - 1)) begin
          st_n = ST_FIN;
        end else begin
          stg_n = stg + SW'(1);
          grp_n = '0;
          st_n  = ST_TWC;
        end
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st    <= ST_IDLE;
      m     <= '0;
      stg   <= '0;
      grp   <= '0;
      bi    <= '0;
      inv_q <= 1'b0;
    end else begin
      st  <= st_n;
      m   <= m_n;
      stg <= stg_n;
      grp <= grp_n;
      bi  <= bi_n;
      if (st == ST_IDLE && start) inv_q <= inverse;
    end
  end

  // twiddle and product registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      wr_q <= '0;
      wi_q <= '0;
      for (int g = 0; g < NMUL; g++) prod_q[g] <= '0;
    end else begin
      if (st == ST_TWC) wr_q <= rom_d;
      if (st == ST_TWS) wi_q <= inv_q ? rom_d : -rom_d;
      if (st == ST_BFM) begin
        for (int g = 0; g < NMUL; g++) prod_q[g] <= mul_p[g];
      end
    end
  end

  // row storage: load, swap, butterfly write-back
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int k = 0; k < NPTS; k++) begin
        xr[k] <= '0;
        xi[k] <= '0;
      end
    end else if (st == ST_IDLE && start) begin
      for (int k = 0; k < NPTS; k++) begin
        xr[k] <= re_in[k*DW +: DW];
        xi[k] <= im_in[k*DW +: DW];
      end
    end else if (st == ST_REORD && do_swap) begin
      xr[m]  <= xr[mr];
      xr[mr] <= xr[m];
      xi[m]  <= xi[mr];
      xi[mr] <= xi[m];
    end else if (st == ST_BFU) begin
      xr[bi]    <= qr_s + tr_s;
      xi[bi]    <= qi_s + ti_s;
      xr[j_idx] <= qr_s - tr_s;
      xi[j_idx] <= qi_s - ti_s;
    end
  end

  for (genvar k = 0; k < NPTS; k++) begin : g_pack
    assign re_out[k*DW +: DW] = xr[k];
    assign im_out[k*DW +: DW] = xi[k];
  end

  assign done = (st == ST_FIN);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);

  // R5
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> $past(st == ST_BFU));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st != ST_IDLE && st != ST_FIN) |=> (st != ST_IDLE));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st != ST_IDLE) |=> $stable(inv_q));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_IDLE && !start) |=> ($stable(re_out) && $stable(im_out)));

  // R2
  reorder_exit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_REORD) |=> (st == ST_REORD || st == ST_TWC));

  // R4
  stage_span_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_BFM) |-> ($onehot(span) && (grp < span)));

endmodule

// File: tb/tb_fft_row_engine.sv
module tb_fft_row_engine;
  localparam int N    = 32;
  localparam int DW   = 27;
  localparam int LOGN = 5;
  localparam int LAT  = N + 2 * (N - 1) + N * LOGN;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            inverse;
  logic [N*DW-1:0] re_in, im_in, re_out, im_out;
  logic            done;

  int n_tests;
  int n_fail;

  longint in_re [N];
  longint in_im [N];
  longint ex_re [N];
  longint ex_im [N];

  fft_row_engine dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .inverse (inverse),
    .re_in   (re_in),
    .im_in   (im_in),
    .re_out  (re_out),
    .im_out  (im_out),
    .done    (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic longint wrap27(input longint v);
    longint t;
    t = v & ((64'sd1 <<< DW) - 1);
    if (t >= (64'sd1 <<< (DW - 1))) t = t - (64'sd1 <<< DW);
    return t;
  endfunction

  function automatic longint sine_q(input int k);
    return longint'($rtoi($floor($sin(6.283185307179586 * real'(k) / real'(N)) * 128.0 + 0.5)));
  endfunction

  function automatic longint fxm(input longint a, input longint b);
    return wrap27((a * b) >>> 7);
  endfunction

  function automatic longint get_el(input logic [N*DW-1:0] v, input int k);
    return longint'($signed(v[k*DW +: DW]));
  endfunction

  task automatic reference(input bit inv);
    longint yr [N];
    longint yi [N];
    for (int n = 0; n < N; n++) begin
      int r;
      r = 0;
      for (int b = 0; b < LOGN; b++) r = r | (((n >> b) & 1) << (LOGN - 1 - b));
      yr[r] = in_re[n];
      yi[r] = in_im[n];
    end
    for (int L = 1; L < N; L = L * 2) begin
      for (int g = 0; g < L; g++) begin
        int k;
        longint wr, wi;
        k  = g * (N / (2 * L));
        wr = sine_q((k + N / 4) % N);
        wi = inv ? sine_q(k) : -sine_q(k);
        for (int i = g; i < N; i = i + 2 * L) begin
          longint tr, ti, qr, qi;
          tr = wrap27(fxm(wr, yr[i+L]) - fxm(wi, yi[i+L]));
          ti = wrap27(fxm(wr, yi[i+L]) + fxm(wi, yr[i+L]));
          qr = yr[i];
          qi = yi[i];
          if (!inv) begin
            tr = tr >>> 1; ti = ti >>> 1; qr = qr >>> 1; qi = qi >>> 1;
          end
          yr[i+L] = wrap27(qr - tr);
          yi[i+L] = wrap27(qi - ti);
          yr[i]   = wrap27(qr + tr);
          yi[i]   = wrap27(qi + ti);
        end
      end
    end
    for (int n = 0; n < N; n++) begin
      ex_re[n] = yr[n];
      ex_im[n] = yi[n];
    end
  endtask

  task automatic compare_out(input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < N; k++) begin
      if (bad < 0 && (get_el(re_out, k) != ex_re[k] || get_el(im_out, k) != ex_im[k])) bad = k;
    end
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s element %0d actual (%0d,%0d) expected (%0d,%0d)", req, bad,
               get_el(re_out, bad), get_el(im_out, bad), ex_re[bad], ex_im[bad]);
    end
  endtask

  task automatic pack_inputs();
    for (int k = 0; k < N; k++) begin
      re_in[k*DW +: DW] = DW'(in_re[k]);
      im_in[k*DW +: DW] = DW'(in_im[k]);
    end
  endtask

  // one transform; done is checked on every clock (R5), results at done (req),
  // again three cycles later (R7); disturb issues a mid-run start (R6)
  task automatic run(input bit inv, input string req, input bit disturb);
    reference(inv);
    @(negedge clk);
    pack_inputs();
    inverse = inv;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= LAT + 3; c++) begin
      @(negedge clk);
      n_tests++;
      if (done !== (c == LAT)) begin
        n_fail++;
        $display("FAIL R5 cycle %0d done actual %0b expected %0b", c, done, (c == LAT));
      end
      if (c == LAT) compare_out(req);
      if (disturb && c == 40) begin
        re_in   = ~re_in;
        im_in   = {N{27'sd5}};
        inverse = ~inv;
        start   = 1'b1;
      end
      if (disturb && c == 41) start = 1'b0;
    end
    compare_out("R7");
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    inverse = 1'b0;
    re_in   = '0;
    im_in   = '0;
    repeat (4) @(negedge clk);

    // R1: during reset
    n_tests++;
    if (done !== 1'b0 || re_out !== '0 || im_out !== '0) begin
      n_fail++;
      $display("FAIL R1 in reset done=%0b re_or=%0b im_or=%0b expected 0", done, |re_out, |im_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (done !== 1'b0 || re_out !== '0 || im_out !== '0) begin
      n_fail++;
      $display("FAIL R1 after reset done=%0b re_or=%0b im_or=%0b expected 0", done, |re_out, |im_out);
    end

    // R2: forward impulse, flat 128
    for (int k = 0; k < N; k++) begin in_re[k] = 0; in_im[k] = 0; end
    in_re[0] = 4096;
    run(1'b0, "R2", 1'b0);
    n_tests++;
    if (get_el(re_out, 5) != 128 || get_el(im_out, 21) != 0) begin
      n_fail++;
      $display("FAIL R2 impulse bins actual (%0d,%0d) expected (128,0)", get_el(re_out, 5), get_el(im_out, 21));
    end

    // R3: inverse impulse, no scaling
    for (int k = 0; k < N; k++) begin in_re[k] = 0; in_im[k] = 0; end
    in_re[0] = 128;
    run(1'b1, "R3", 1'b0);
    n_tests++;
    if (get_el(re_out, 31) != 128) begin
      n_fail++;
      $display("FAIL R3 unscaled element 31 actual %0d expected 128", get_el(re_out, 31));
    end

    // R4: inverse single bin rotates positively
    for (int k = 0; k < N; k++) begin in_re[k] = 0; in_im[k] = 0; end
    in_re[1] = 1280;
    run(1'b1, "R4", 1'b0);
    n_tests++;
    if (get_el(im_out, 8) <= 0) begin
      n_fail++;
      $display("FAIL R4 imag element 8 actual %0d expected >0 (%0d)", get_el(im_out, 8), ex_im[8]);
    end

    // R9: ramp exposes ordering and packing
    for (int k = 0; k < N; k++) begin in_re[k] = k * 128; in_im[k] = -(k * 37); end
    run(1'b0, "R9", 1'b0);

    // R6: mid-run start with other data and direction is ignored
    for (int k = 0; k < N; k++) begin in_re[k] = (k % 5) * 300 - 600; in_im[k] = k * 11; end
    run(1'b0, "R6", 1'b1);

    // R8: random rows both directions
    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < N; k++) begin
        in_re[k] = longint'($urandom_range(65535)) - 32768;
        in_im[k] = longint'($urandom_range(65535)) - 32768;
      end
      run(t[0], "R8", 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule